// File: doc/BRIEF.md
# Role-Tagged Triple-DES Key Slot Store

This block keeps six single-DES keys for an on-chip triple-DES configuration decryptor. Each slot holds a 56-bit key and three independent role flags: first, middle and last. The flags tell the engine which slots can serve as the first, second and third DES pass. A key set is requested by naming the slot of its first key. The block then finds the middle and last keys among the flagged slots that follow it, and returns all three keys to the engine one cycle later.

Writes come only from the programming interface, and only while that interface is in key-entry mode. The only path that reads keys is the three-key result bus to the cipher engine, and a key appears on that bus only in the cycle of a successful lookup. A tamper or loss-of-backup-power signal wipes every key and flag at the next clock edge. This wipe has priority over any write or lookup in the same cycle.

When the first slot is flagged both first and last, the set is a 2-key set. The last pass then reuses the first key, so six slots can hold three 2-key sets or two 3-key sets. If a set cannot be resolved, the block reports an error instead of a key set, and the engine must not start.

Top module: `key_slot_store`

## Requirements
- R1: A write with `key_mode` high stores `wr_key` and `wr_flags` into slot `wr_slot` (0..5) at the clock edge. Flag bit 0 is first, bit 1 is middle, bit 2 is last. The stored contents are observable through a later lookup.
- R2: A write is ignored when `key_mode` is low or when `wr_slot` is 6 or 7, and the store is left unchanged.
- R3: A lookup requested with `rd_req` in one cycle reports after the next edge. Exactly one of `rd_valid` or `rd_err` is high, and only for that one cycle. Neither is high in a cycle that follows no request.
- R4: The requested index `rd_first` must be below 6 and must name a slot whose first flag is set. Otherwise the lookup reports `rd_err`.
- R5: The middle key is taken from the lowest-numbered slot above the first slot that has its middle flag set.
- R6: If the first slot also has its last flag set, the last key is the first slot's key (2-key set). Otherwise the last key is taken from the lowest-numbered slot above the middle slot that has its last flag set.
- R7: If no middle slot or no last slot can be found, the lookup reports `rd_err` and `rd_valid` stays low.
- R8: `zeroize` clears every key and every flag at the next edge. Every lookup after that reports `rd_err`. A lookup requested in the zeroize cycle also reports `rd_err`.
- R9: A write issued in the same cycle as `zeroize` is discarded.
- R10: After reset, the store is empty and `rd_valid`, `rd_err` and the three key outputs are zero.
- R11: The three key outputs are zero in every cycle in which `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| zeroize | input | 1 | Tamper / backup-power-loss wipe |
| key_mode | input | 1 | Programming interface is in key-entry mode |
| wr_en | input | 1 | Slot write strobe |
| wr_slot | input | 3 | Slot index to write |
| wr_key | input | 56 | Key value to write |
| wr_flags | input | 3 | Role flags: bit0 first, bit1 middle, bit2 last |
| rd_req | input | 1 | Engine lookup request |
| rd_first | input | 3 | Slot index of the set's first key |
| rd_valid | output | 1 | Key set resolved, keys valid this cycle |
| rd_err | output | 1 | Key set could not be resolved |
| key_first | output | 56 | Key for the first DES pass |
| key_mid | output | 56 | Key for the middle DES pass |
| key_last | output | 56 | Key for the last DES pass |

## Verification
The bench drives many pseudo-random flag layouts across all six slots and looks up every index from 0 to 7. This catches a resolver that picks the highest matching slot instead of the lowest, that searches from the wrong point, or that accepts a middle or last slot at or below the first. Hand-built 2-key and 3-key layouts test the rule that reuses the first key as the last key; a design that got this wrong would report an error, or return a later slot, for every 2-key set. Separate cases write with key-entry mode off, write to slots 6 and 7, and write in the same cycle as zeroize. A store that leaks such a write would later return the leaked key. The bench also checks that no key is visible while `rd_valid` is low, which catches a design that leaves the last result on the bus.

// File: rtl/kss_pkg.sv
// Package: shared constants for the role-tagged key slot store.
// Assumes: flag vectors are FLG_W bits, with one bit per triple-DES pass role.
package kss_pkg;
    localparam int unsigned FLG_W     = 3;
    localparam int unsigned FLG_FIRST = 0;
    localparam int unsigned FLG_MID   = 1;
    localparam int unsigned FLG_LAST  = 2;
endpackage

// File: rtl/kss_slot_array.sv
// Module: key and role-flag storage with gated writes and a priority wipe.
// Assumes: zeroize may arrive in any cycle; it outranks writes and reset is synchronous.
module kss_slot_array
    import kss_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 6,
    parameter int unsigned KEY_W     = 56,
    parameter int unsigned IDX_W     = $clog2(NUM_SLOTS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              zeroize,
    input  logic                              key_mode,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_slot,
    input  logic [KEY_W-1:0]                  wr_key,
    input  logic [FLG_W-1:0]                  wr_flags,
    output logic [NUM_SLOTS-1:0][KEY_W-1:0]   slot_keys,
    output logic [NUM_SLOTS-1:0][FLG_W-1:0]   slot_flags
);

    logic wr_ok;

    // Write is allowed only in key-entry mode and never during a wipe.
    always_comb wr_ok = wr_en && key_mode && !zeroize;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        // Per-slot register: reset or wipe clears it, and a matching write loads it.
        always_ff @(posedge clk) begin
            if (!rst_n || zeroize) begin
                slot_keys[s]  <= '0;
                slot_flags[s] <= '0;
            end else if (wr_ok && wr_slot == IDX_W'(s)) begin
                slot_keys[s]  <= wr_key;
                slot_flags[s] <= wr_flags;
            end
        end
    end

    assert_zeroize_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        zeroize |=> (slot_keys == '0 && slot_flags == '0));

    assert_locked_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_mode && !zeroize) |=> ($stable(slot_keys) && $stable(slot_flags)));

endmodule

// File: rtl/kss_set_resolver.sv
// Module: combinational search for the middle and last slots of a requested key set.
// Assumes: lower slot numbers win; a first slot that is also flagged last forms a 2-key set.
module kss_set_resolver
    import kss_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 6,
    parameter int unsigned IDX_W     = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS-1:0][FLG_W-1:0] slot_flags,
    input  logic [IDX_W-1:0]                first_idx,
    output logic                            set_ok,
    output logic [IDX_W-1:0]                mid_idx,
    output logic [IDX_W-1:0]                last_idx
);

    logic first_ok;
    logic two_key;
    logic mid_hit;
    logic last_hit;

    // Validate the first slot, then scan upward for the middle and last roles.
    always_comb begin
        first_ok = 1'b0;
        two_key  = 1'b0;
        mid_hit  = 1'b0;
        last_hit = 1'b0;
        mid_idx  = '0;
        last_idx = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (first_idx == IDX_W'(i) && slot_flags[i][FLG_FIRST]) first_ok = 1'b1;
            if (first_idx == IDX_W'(i) && slot_flags[i][FLG_LAST])  two_key  = 1'b1;
        end
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (!mid_hit && IDX_W'(i) > first_idx && slot_flags[i][FLG_MID]) begin
                mid_hit = 1'b1;
                mid_idx = IDX_W'(i);
            end
        end
        if (two_key) begin
            last_hit = 1'b1;
            last_idx = first_idx;
        end else begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (!last_hit && mid_hit && IDX_W'(i) > mid_idx && slot_flags[i][FLG_LAST]) begin
                    last_hit = 1'b1;
                    last_idx = IDX_W'(i);
                end
            end
        end
        set_ok = first_ok && mid_hit && last_hit;
    end

endmodule

// File: rtl/key_slot_store.sv
// Module: six-slot role-tagged DES key store, with a registered lookup port for the cipher engine.
// Assumes: the lookup result is the only key egress; keys are driven only while rd_valid is high.
module key_slot_store
    import kss_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 6,
    parameter int unsigned KEY_W     = 56,
    parameter int unsigned IDX_W     = $clog2(NUM_SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             zeroize,
    input  logic             key_mode,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_slot,
    input  logic [KEY_W-1:0] wr_key,
    input  logic [2:0]       wr_flags,
    input  logic             rd_req,
    input  logic [IDX_W-1:0] rd_first,
    output logic             rd_valid,
    output logic             rd_err,
    output logic [KEY_W-1:0] key_first,
    output logic [KEY_W-1:0] key_mid,
    output logic [KEY_W-1:0] key_last
);

    logic [NUM_SLOTS-1:0][KEY_W-1:0] slot_keys;
    logic [NUM_SLOTS-1:0][FLG_W-1:0] slot_flags;
    logic                            set_ok;
    logic [IDX_W-1:0]                mid_idx;
    logic [IDX_W-1:0]                last_idx;

    kss_slot_array #(.NUM_SLOTS(NUM_SLOTS), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_array (
        .clk(clk), .rst_n(rst_n), .zeroize(zeroize), .key_mode(key_mode),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_key(wr_key), .wr_flags(wr_flags),
        .slot_keys(slot_keys), .slot_flags(slot_flags)
    );

    kss_set_resolver #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_resolve (
        .slot_flags(slot_flags), .first_idx(rd_first),
        .set_ok(set_ok), .mid_idx(mid_idx), .last_idx(last_idx)
    );

    // Select one stored key by slot index; an index out of range yields zero.
    function automatic logic [KEY_W-1:0] pick(input logic [NUM_SLOTS-1:0][KEY_W-1:0] keys,
                                              input logic [IDX_W-1:0] idx);
        logic [KEY_W-1:0] k;
        k = '0;
        for (int i = 0; i < NUM_SLOTS; i++)
            if (idx == IDX_W'(i)) k = keys[i];
        return k;
    endfunction

    // Register the lookup outcome: keys on success, an error pulse otherwise, and nothing during a wipe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            rd_err    <= 1'b0;
            key_first <= '0;
            key_mid   <= '0;
            key_last  <= '0;
        end else if (rd_req && set_ok && !zeroize) begin
            rd_valid  <= 1'b1;
            rd_err    <= 1'b0;
            key_first <= pick(slot_keys, rd_first);
            key_mid   <= pick(slot_keys, mid_idx);
            key_last  <= pick(slot_keys, last_idx);
        end else begin
            rd_valid  <= 1'b0;
            rd_err    <= rd_req;
            key_first <= '0;
            key_mid   <= '0;
            key_last  <= '0;
        end
    end

    assert_result_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && rd_err));

    assert_result_needs_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !(rd_valid || rd_err));

    assert_keys_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (key_first == '0 && key_mid == '0 && key_last == '0));

    assert_wipe_blocks_lookup_R8: assert property (@(posedge clk) disable iff (!rst_n)
        zeroize |=> !rd_valid);

endmodule

// File: tb/key_slot_store_tb.sv
// Bench: swept flag layouts plus directed 2-key/3-key, locked-write and wipe cases, checked against a bench model.
module key_slot_store_tb;

    localparam int KW = 56;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          zeroize = 1'b0;
    logic          key_mode = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_slot = '0;
    logic [KW-1:0] wr_key = '0;
    logic [2:0]    wr_flags = '0;
    logic          rd_req = 1'b0;
    logic [2:0]    rd_first = '0;
    logic          rd_valid;
    logic          rd_err;
    logic [KW-1:0] key_first;
    logic [KW-1:0] key_mid;
    logic [KW-1:0] key_last;

    int errors = 0;
    int checks = 0;
    logic [KW-1:0] m_key  [6];
    logic [2:0]    m_flag [6];
    logic [31:0]   seed = 32'h1badf00d;

    key_slot_store u_dut (
        .clk(clk), .rst_n(rst_n), .zeroize(zeroize), .key_mode(key_mode),
        .wr_en(wr_en), .wr_slot(wr_slot), .wr_key(wr_key), .wr_flags(wr_flags),
        .rd_req(rd_req), .rd_first(rd_first), .rd_valid(rd_valid), .rd_err(rd_err),
        .key_first(key_first), .key_mid(key_mid), .key_last(key_last)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [3*KW+1:0] act, input logic [3*KW+1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        return y ^ (y << 5);
    endfunction

    task automatic wr(input int s, input logic [KW-1:0] k, input logic [2:0] f,
                      input logic mode, input logic zap);
        @(negedge clk);
        wr_en = 1'b1; wr_slot = 3'(s); wr_key = k; wr_flags = f; key_mode = mode; zeroize = zap;
        @(negedge clk);
        wr_en = 1'b0; key_mode = 1'b0; zeroize = 1'b0;
        if (zap) begin
            for (int i = 0; i < 6; i++) begin m_key[i] = '0; m_flag[i] = '0; end
        end else if (mode && s < 6) begin
            m_key[s] = k; m_flag[s] = f;
        end
    endtask

    // Expected lookup per R4-R7: bit0 first, bit1 middle, bit2 last; lowest slot wins.
    task automatic expect_set(input int f, output logic ok, output logic [3*KW-1:0] keys);
        int mi, li;
        ok = 1'b0; keys = '0; mi = -1; li = -1;
        if (f < 6 && m_flag[f][0]) begin
            for (int i = 5; i > f; i--) if (m_flag[i][1]) mi = i;
            if (mi >= 0) begin
                if (m_flag[f][2]) li = f;
                else for (int i = 5; i > mi; i--) if (m_flag[i][2]) li = i;
            end
            if (mi >= 0 && li >= 0) begin
                ok = 1'b1;
                keys = {m_key[f], m_key[mi], m_key[li]};
            end
        end
    endtask

    task automatic lookup(input int f, input string req, input logic check_drop);
        logic ok;
        logic [3*KW-1:0] keys;
        expect_set(f, ok, keys);
        @(negedge clk);
        rd_req = 1'b1; rd_first = 3'(f);
        @(negedge clk);
        rd_req = 1'b0;
        check(req, {rd_valid, rd_err, key_first, key_mid, key_last}, {ok, !ok, keys});
        if (check_drop) begin
            @(negedge clk);
            check("R3 R11 single-cycle pulse", {rd_valid, rd_err, key_first, key_mid, key_last}, '0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 6; i++) begin m_key[i] = '0; m_flag[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset state", {rd_valid, rd_err, key_first, key_mid, key_last}, '0);
        lookup(0, "R10 empty store errors", 1'b0);

        // 3-key sets: first, middle, last twice.
        for (int s = 0; s < 6; s++) wr(s, 56'h11_0000_0000_0000 + KW'(s), (s % 3 == 0) ? 3'b001 : (s % 3 == 1) ? 3'b010 : 3'b100, 1'b1, 1'b0);
        lookup(0, "R1 R5 R6 3-key set A", 1'b1);
        lookup(3, "R5 R6 3-key set B", 1'b0);
        lookup(1, "R4 non-first slot", 1'b0);
        lookup(6, "R4 index 6", 1'b0);
        lookup(7, "R4 index 7", 1'b0);

        // 2-key sets: first+last, middle, three times.
        for (int s = 0; s < 6; s++) wr(s, 56'h22_0000_0000_0000 + KW'(s), (s % 2 == 0) ? 3'b101 : 3'b010, 1'b1, 1'b0);
        for (int f = 0; f < 6; f += 2) lookup(f, "R6 2-key reuses first key", 1'b0);
        lookup(5, "R4 R7 middle-only slot", 1'b0);

        // Locked writes: mode low, and slot out of range.
        wr(0, 56'hDEAD_0000_0000_00, 3'b111, 1'b0, 1'b0);
        lookup(0, "R2 write without key mode ignored", 1'b0);
        wr(6, 56'hBEEF_0000_0000_00, 3'b111, 1'b1, 1'b0);
        wr(7, 56'hBEEF_1111_0000_00, 3'b111, 1'b1, 1'b0);
        for (int f = 0; f < 6; f++) lookup(f, "R2 out-of-range slot ignored", 1'b0);

        // Middle found but no last after it.
        wr(0, 56'h33_0000_0000_0001, 3'b001, 1'b1, 1'b0);
        wr(1, 56'h33_0000_0000_0002, 3'b010, 1'b1, 1'b0);
        for (int s = 2; s < 6; s++) wr(s, 56'h33_0000_0000_0010 + KW'(s), 3'b010, 1'b1, 1'b0);
        lookup(0, "R7 missing last key", 1'b0);

        // Swept pseudo-random layouts, every index looked up.
        for (int p = 0; p < 60; p++) begin
            for (int s = 0; s < 6; s++) begin
                seed = nxt(seed);
                wr(s, {seed[23:0], 32'(p * 8 + s)}, seed[31:29], 1'b1, 1'b0);
            end
            for (int f = 0; f < 8; f++) lookup(f, "R4 R5 R6 R7 swept layout", (f == 0));
        end

        // Wipe: write in the same cycle is lost; everything clears.
        for (int s = 0; s < 6; s++) wr(s, 56'h44_0000_0000_0000 + KW'(s), (s % 3 == 0) ? 3'b001 : (s % 3 == 1) ? 3'b010 : 3'b100, 1'b1, 1'b0);
        lookup(0, "R1 set before wipe", 1'b0);
        wr(0, 56'h55_5555_5555_5555, 3'b111, 1'b1, 1'b1);
        for (int f = 0; f < 6; f++) lookup(f, "R8 R9 store empty after wipe", 1'b0);
        wr(1, 56'h66_0000_0000_0001, 3'b010, 1'b1, 1'b0);
        wr(2, 56'h66_0000_0000_0002, 3'b100, 1'b1, 1'b0);
        lookup(0, "R9 zeroize-cycle write discarded", 1'b0);

        // Lookup requested during the wipe cycle.
        wr(0, 56'h77_0000_0000_0000, 3'b001, 1'b1, 1'b0);
        @(negedge clk);
        rd_req = 1'b1; rd_first = 3'd0; zeroize = 1'b1;
        @(negedge clk);
        rd_req = 1'b0; zeroize = 1'b0;
        for (int i = 0; i < 6; i++) begin m_key[i] = '0; m_flag[i] = '0; end
        check("R8 lookup in wipe cycle errors", {rd_valid, rd_err, key_first, key_mid, key_last}, {1'b0, 1'b1, {(3*KW){1'b0}}});

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule